// File: doc/BRIEF.md
# Raster Timing Generator with Scanline Interrupt

This block produces 640x480 monitor raster timing from a single-cycle pixel-clock enable. A column counter and a line counter step once per enabled clock. From them the block decodes an active-low horizontal sync, an active-low vertical sync and a display-enable that is high only over the visible picture. The current column and line are exported so that a renderer or a CPU can follow the beam.

Software programs a target scanline and chooses where in that line a single interrupt event lands. Three points are available: the first clock after the last visible pixel, which is the start of the blanking interval; the clock where horizontal sync begins; and the first clock after horizontal sync ends. The event sets a sticky status flag. The flag drives a level interrupt output while the line-interrupt enable bit is set. Software clears the flag by writing one to it.

The register port is a plain write strobe with a combinational read mux. No data streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `raster_irq_gen`

## Requirements
- R1: `cur_col` counts from 0 to 799 and then wraps to 0, advancing `cur_line` by one. `de` is 1 exactly when the column is below 640 and the line is below 480.
- R2: The counters advance only on clocks where `pix_ce` is 1. With `pix_ce` at 0 they hold their value.
- R3: `hsync_n` is 0 for columns 656 through 751 (a 16-column front porch after the picture, then 96 columns of sync, then a 48-column back porch). It is 1 everywhere else.
- R4: `cur_line` counts from 0 to 524 and then wraps to 0. Line 0 is the first visible line. `vsync_n` is 0 on lines 490 and 491 (10 porch lines after the picture, 2 sync lines, 33 back-porch lines). It is 1 everywhere else.
- R5: The line flag (status bit 0) rises in the first cycle in which the raster shows the target line and the selected column. With select value 0 or 3, that column is 640.
- R6: Select value 1 places the event at column 656, the start of hsync. Select value 2 places it at column 752, the first column after hsync.
- R7: The event occurs at most once per frame. A target of 525 or higher never sets the flag.
- R8: Writing to address 2 with data bit 0 set clears the flag. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R9: If the event and a clearing write fall in the same clock, the flag ends up set.
- R10: `irq` equals the flag ANDed with enable bit 1 (of the 4-bit enable field at address 1, bits 3:0). Enable bits 0, 2 and 3 have no effect on `irq`.
- R11: The register map reads back as follows. Address 0 holds the target line in bits 9:0. Address 1 holds the enable field in bits 3:0 and the select in bits 5:4. Address 2 holds the flag in bit 0 and an on-screen bit in bit 1, which equals `de`. Address 3 returns the current line.
- R12: After reset, column and line are 0, both syncs are 1, the target, enable and select are 0, and the flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable; one pixel per enabled clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data (combinational) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable (visible area) |
| cur_col | output | 10 | Current column |
| cur_line | output | 10 | Current line |
| irq | output | 1 | Level interrupt: flag AND line enable |

## Verification
The line event and a software write-one-to-clear of the flag can land on the same clock edge. The bench sets the flag on one frame and leaves it set. On the next frame it waits until the raster sits one column before the selected point on the target line, and it issues the clearing write in that cycle. The flag must read 1 afterwards. A clearing write issued one cycle earlier must drop the flag for exactly one cycle before the event sets it again.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // trigger point select encoding; 3 aliases the default
  typedef enum logic [1:0] {
    TRIG_VIS_END  = 2'd0,
    TRIG_HS_START = 2'd1,
    TRIG_HS_END   = 2'd2,
    TRIG_VIS_ALT  = 2'd3
  } trig_sel_e;

  localparam logic [1:0] ADDR_TARGET = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STAT   = 2'd2;
  localparam logic [1:0] ADDR_LINE   = 2'd3;

  localparam int IEN_W        = 4;
  localparam int IEN_LINE_BIT = 1;

endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int LINE_W = 10,
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  output logic [LINE_W-1:0] h_cnt,
  output logic [LINE_W-1:0] v_cnt
);
  localparam logic [LINE_W-1:0] H_LAST = LINE_W'(H_TOTAL - 1);
  localparam logic [LINE_W-1:0] V_LAST = LINE_W'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (ce) begin
      if (h_cnt == H_LAST) begin
        h_cnt <= '0;
        v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end

  a_r1_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && h_cnt == H_LAST) |=> (h_cnt == '0));

  a_r2_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(h_cnt) && $stable(v_cnt)));

  a_r4_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt <= V_LAST);

endmodule

// File: rtl/raster_sync.sv
module raster_sync #(
  parameter int LINE_W = 10,
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] h_cnt,
  input  logic [LINE_W-1:0] v_cnt,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de
);
  localparam logic [LINE_W-1:0] HS_BEG = LINE_W'(H_VIS + H_FP);
  localparam logic [LINE_W-1:0] HS_END = LINE_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [LINE_W-1:0] VS_BEG = LINE_W'(V_VIS + V_FP);
  localparam logic [LINE_W-1:0] VS_END = LINE_W'(V_VIS + V_FP + V_SYNC);
  localparam logic [LINE_W-1:0] H_VEND = LINE_W'(H_VIS);
  localparam logic [LINE_W-1:0] V_VEND = LINE_W'(V_VIS);

  always_comb begin
    hsync_n = !((h_cnt >= HS_BEG) && (h_cnt < HS_END));
    vsync_n = !((v_cnt >= VS_BEG) && (v_cnt < VS_END));
    de      = (h_cnt < H_VEND) && (v_cnt < V_VEND);
  end

  a_r3_hsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !de);

  a_r4_vsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !de);

endmodule

// File: rtl/line_trigger.sv
module line_trigger
  import raster_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [LINE_W-1:0] h_cnt,
  input  logic [LINE_W-1:0] v_cnt,
  input  logic [LINE_W-1:0] target,
  input  trig_sel_e         sel,
  output logic              trig
);
  localparam logic [LINE_W-1:0] P_VIS = LINE_W'(H_VIS);
  localparam logic [LINE_W-1:0] P_HSB = LINE_W'(H_VIS + H_FP);
  localparam logic [LINE_W-1:0] P_HSE = LINE_W'(H_VIS + H_FP + H_SYNC);

  logic [LINE_W-1:0] point;

  always_comb begin
    case (sel)
      TRIG_HS_START: point = P_HSB;
      TRIG_HS_END:   point = P_HSE;
      default:       point = P_VIS;
    endcase
    // all points are nonzero, so the step into them never crosses a line
    trig = ce && (h_cnt == point - 1'b1) && (v_cnt == target);
  end

  a_r5_lands_on_point: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (h_cnt == $past(point)) && (v_cnt == $past(target)));

endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] rdata,
  input  logic              trig,
  input  logic              on_screen,
  input  logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] target,
  output trig_sel_e         sel,
  output logic              irq
);
  logic [IEN_W-1:0] ien;
  logic             flag;
  logic             clr;
  logic             wdata_unused;

  assign clr = wr && (addr == ADDR_STAT) && wdata[0];
  assign wdata_unused = ^wdata[LINE_W-1:6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
      ien    <= '0;
      sel    <= TRIG_VIS_END;
      flag   <= 1'b0;
    end else begin
      if (wr && addr == ADDR_TARGET) target <= wdata;
      if (wr && addr == ADDR_CTRL) begin
        ien <= wdata[IEN_W-1:0];
        sel <= trig_sel_e'(wdata[5:4]);
      end
      if (trig)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign irq = flag & ien[IEN_LINE_BIT];

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_TARGET: rdata = target;
      ADDR_CTRL:   rdata = LINE_W'({sel, ien});
      ADDR_STAT:   rdata = LINE_W'({on_screen, flag});
      default:     rdata = line;
    endcase
  end

  a_r9_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> flag);

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !trig) |=> !flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r5_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(trig));

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [LINE_W-1:0] reg_wdata,
  output logic [LINE_W-1:0] reg_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [LINE_W-1:0] cur_col,
  output logic [LINE_W-1:0] cur_line,
  output logic              irq
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

  logic [LINE_W-1:0] h_cnt, v_cnt, target;
  trig_sel_e         sel;
  logic              trig;

  raster_counters #(.LINE_W(LINE_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce), .h_cnt(h_cnt), .v_cnt(v_cnt));

  raster_sync #(.LINE_W(LINE_W), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
                .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de));

  line_trigger #(.LINE_W(LINE_W), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC)) u_trig (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .target(target), .sel(sel), .trig(trig));

  raster_regs #(.LINE_W(LINE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .trig(trig), .on_screen(de), .line(v_cnt),
    .target(target), .sel(sel), .irq(irq));

  assign cur_col  = h_cnt;
  assign cur_line = v_cnt;

  a_r10_irq_only_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_wr || reg_addr != ADDR_STAT || reg_rdata[0]);

endmodule

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
  localparam int LW = 10;
  localparam int HV = 16, HFP = 4, HS = 6, HBP = 6, HT = HV + HFP + HS + HBP;
  localparam int VV = 10, VFP = 2, VS = 2, VBP = 3, VT = VV + VFP + VS + VBP;
  localparam int P0 = HV, P1 = HV + HFP, P2 = HV + HFP + HS;
  localparam int TL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [LW-1:0] reg_wdata = '0;
  logic [LW-1:0] reg_rdata, cur_col, cur_line;
  logic hsync_n, vsync_n, de, irq;

  int nchk = 0, nbad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  raster_irq_gen #(.LINE_W(LW), .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
                   .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)) i_raster_irq_gen (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .cur_col(cur_col), .cur_line(cur_line), .irq(irq));

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, int d);
    reg_addr = a; reg_wdata = LW'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a; #0.5; v = int'(reg_rdata); reg_addr = 2'd2; #0.5;
  endtask

  task automatic wait_pos(int h, int v);
    for (int i = 0; i < 2 * HT * VT; i++) begin
      if (int'(cur_col) == h && int'(cur_line) == v) return;
      @(negedge clk);
    end
    nchk++; nbad++;
    $display("FAIL wait position actual=%0d/%0d expected=%0d/%0d", cur_col, cur_line, h, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_ce = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; pix_ce = 1'b1;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R12", "col", int'(cur_col), 0);
    chk("R12", "line", int'(cur_line), 0);
    chk("R12", "hsync_n", int'(hsync_n), 1);
    chk("R12", "vsync_n", int'(vsync_n), 1);
    chk("R12", "irq", int'(irq), 0);
    rd(2'd0, v); chk("R12", "target", v, 0);
    rd(2'd1, v); chk("R12", "ctrl", v, 0);
    rd(2'd2, v); chk("R12", "flag", v & 1, 0);
  endtask

  task automatic t_raster_walk();
    int eh = 0, ev = 0;
    do_reset();
    for (int n = 0; n < HT * VT + 2; n++) begin
      chk("R1", "col", int'(cur_col), eh);
      chk("R4", "line", int'(cur_line), ev);
      chk("R1", "de", int'(de), (eh < HV && ev < VV) ? 1 : 0);
      chk("R3", "hsync_n", int'(hsync_n), (eh >= HV + HFP && eh < HV + HFP + HS) ? 0 : 1);
      chk("R4", "vsync_n", int'(vsync_n), (ev >= VV + VFP && ev < VV + VFP + VS) ? 0 : 1);
      @(negedge clk);
      if (eh == HT - 1) begin eh = 0; ev = (ev == VT - 1) ? 0 : ev + 1; end
      else eh++;
    end
  endtask

  task automatic t_pix_ce();
    int h0, l0, steps;
    wait_pos(5, 1);
    pix_ce = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2", "col held", int'(cur_col), 5);
    chk("R2", "line held", int'(cur_line), 1);
    h0 = int'(cur_col); l0 = int'(cur_line);
    for (int i = 0; i < 20; i++) begin
      pix_ce = (i % 2 == 0);
      @(negedge clk);
    end
    pix_ce = 1'b1;
    steps = (int'(cur_line) - l0) * HT + int'(cur_col) - h0;
    chk("R2", "steps with half-rate enable", steps, 10);
  endtask

  task automatic t_point(int sel, int p, string req);
    wr(2'd1, (sel << 4) | 2);
    wr(2'd0, TL);
    wait_pos(0, TL + 2);
    wr(2'd2, 1);
    wait_pos(p - 1, TL);
    chk(req, "flag before point", int'(reg_rdata[0]), 0);
    @(negedge clk);
    chk(req, "col at flag rise", int'(cur_col), p);
    chk(req, "flag at point", int'(reg_rdata[0]), 1);
    chk("R10", "irq at point", int'(irq), 1);
  endtask

  task automatic t_once_and_range();
    t_point(0, P0, "R5");
    wr(2'd2, 1);
    wait_pos(HT - 1, VT - 1);
    chk("R7", "no second event in frame", int'(reg_rdata[0]), 0);
    wr(2'd0, VT);
    wait_pos(0, 0);
    @(negedge clk);
    wait_pos(HT - 1, VT - 1);
    chk("R7", "target beyond frame", int'(reg_rdata[0]), 0);
    wr(2'd0, 1000);
    wait_pos(0, 0);
    @(negedge clk);
    wait_pos(HT - 1, VT - 1);
    chk("R7", "target 1000", int'(reg_rdata[0]), 0);
  endtask

  task automatic t_enable_and_w1c();
    t_point(2, P2, "R6");
    wr(2'd1, (2 << 4) | 4'b1101);
    chk("R10", "irq with other enables", int'(irq), 0);
    chk("R10", "flag kept", int'(reg_rdata[0]), 1);
    wr(2'd1, (2 << 4) | 4'b0010);
    chk("R10", "irq re-enabled", int'(irq), 1);
    wr(2'd2, 0);
    chk("R8", "write 0 keeps flag", int'(reg_rdata[0]), 1);
    wr(2'd2, 2);
    chk("R8", "write bit1 keeps flag", int'(reg_rdata[0]), 1);
    wr(2'd2, 1);
    chk("R8", "write 1 clears flag", int'(reg_rdata[0]), 0);
    chk("R10", "irq after clear", int'(irq), 0);
  endtask

  task automatic t_collision();
    wr(2'd1, (1 << 4) | 2);
    wr(2'd0, TL);
    wait_pos(P1, TL);
    @(negedge clk);
    chk("R9", "flag set before collision", int'(reg_rdata[0]), 1);
    wait_pos(P1 - 1, TL);
    wr(2'd2, 1);
    chk("R9", "event beats clear", int'(reg_rdata[0]), 1);
    wait_pos(P1 - 2, TL);
    wr(2'd2, 1);
    chk("R9", "early clear drops flag", int'(reg_rdata[0]), 0);
    @(negedge clk);
    chk("R9", "event sets after early clear", int'(reg_rdata[0]), 1);
  endtask

  task automatic t_regmap();
    int v;
    wr(2'd0, 777);
    rd(2'd0, v); chk("R11", "target readback", v, 777);
    wr(2'd1, 'h3A);
    rd(2'd1, v); chk("R11", "ctrl readback", v, 'h3A);
    wait_pos(5, 2);
    rd(2'd2, v); chk("R11", "on-screen visible", (v >> 1) & 1, 1);
    rd(2'd3, v); chk("R11", "line readback", v, 2);
    wait_pos(HV, 2);
    rd(2'd2, v); chk("R11", "on-screen h blank", (v >> 1) & 1, 0);
    wait_pos(3, VV);
    rd(2'd2, v); chk("R11", "on-screen v blank", (v >> 1) & 1, 0);
  endtask

  initial begin
    t_reset();
    t_raster_walk();
    t_pix_ce();
    t_point(0, P0, "R5");
    t_point(3, P0, "R5");
    t_point(1, P1, "R6");
    t_point(2, P2, "R6");
    t_once_and_range();
    t_enable_and_w1c();
    t_collision();
    t_regmap();
    finish_run();
  end

endmodule